// File: doc/BRIEF.md
# Cascaded 96-Source Interrupt Controller

This block collects 96 interrupt sources for one CPU: 64 level lines from on-chip units, split over a low and a high main cause register, and 32 general-purpose port lines. The port lines are captured on a rising edge into a port cause register that software clears. Four bits of the high main cause register summarise the port cause register, one bit for each group of eight port lines. Through these four bits the port sources chain into the main resolution.

Every cycle the block turns the registered cause and mask state into one interrupt number (0 to 95) or a spurious indication. The low register takes precedence over the high register. If the winning high bit is a port summary bit, the number comes from the masked port cause register. Fixed per-register eligibility filters stop reserved cause bits from ever being resolved. Software acknowledges a port interrupt by writing zeros to the bits it wants to clear. All cause and mask registers sit on a simple single-cycle register bus.

Top module: `pic96_top`

## Requirements
- R1: The low main cause register holds the unit inputs `unit_irq_lo` one clock after they are driven. A pending, eligible, unmasked low bit k resolves to interrupt number k. Among such bits the lowest index wins.
- R2: Only low bits in mask 0x3DFFFFFE and high bits in mask 0x0F000DB7 take part in resolution and in `cpu_irq`. Low bits 0, 25, 30, 31 and high bits 3, 6, 9, 12–23, 28–31 are ignored.
- R3: The high register is consulted only when no eligible, unmasked low bit is pending.
- R4: A winning high bit k below 24 resolves to number 32+k, with the lowest eligible index winning.
- R5: High cause bit 24+g reads as the OR of port cause bits 8g to 8g+7, and the `unit_irq_hi` inputs at bits 24–27 are ignored. When a summary bit wins, the number is 64 plus the lowest pending, unmasked port cause index.
- R6: With no eligible pending source, or with a winning summary bit but no unmasked port bit pending, `irq_valid`=0, `irq_spurious`=1 and `irq_num`=0.
- R7: A rising edge on `gpp_irq[i]` sets port cause bit i one clock later. The bit stays set after the input falls.
- R8: A write to the port cause register clears each bit written 0 and keeps each bit written 1. An edge that arrives in the same cycle as the write leaves its bit set.
- R9: A set mask bit enables its source. After reset the low and port masks are 0 and the high mask is 0x0F000000. Masks read back as written.
- R10: `cpu_irq` is 1 exactly when an eligible, unmasked low or high cause bit is pending. This includes a summary bit whose port bits are all masked.
- R11: Register addresses are: 0 low cause, 1 high cause, 2 port cause, 3 low mask, 4 high mask, 5 port mask. `bus_rdata` is combinational. Writes to addresses 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| unit_irq_lo | input | 32 | Unit interrupt levels, numbers 0–31 |
| unit_irq_hi | input | 32 | Unit interrupt levels, numbers 32–63 |
| gpp_irq | input | 32 | Port interrupt lines, numbers 64–95 |
| cpu_irq | output | 1 | Any eligible unmasked main source pending |
| irq_valid | output | 1 | `irq_num` holds a resolved number |
| irq_num | output | 7 | Resolved interrupt number |
| irq_spurious | output | 1 | Nothing resolvable pending |

## Verification
A table of main-register patterns covers the following cases: single bits, several bits at once, bits outside the eligibility filters, masked bits, and low and high bits pending together. These separate lowest-index priority, the filter constants, the low-before-high order and mask gating. Directed port sequences come next. They raise edges in different byte groups and clear single bits with all-ones-but-one writes. They mask the remaining port bit, and they collide a clear with a new edge. Together these separate summary composition, cascaded numbering, sticky capture, the spurious path while `cpu_irq` stays asserted, and edge-over-clear priority.

// File: rtl/pic96_pkg.sv
package pic96_pkg;
   localparam int DATA_W = 32;
   localparam int NUM_W  = 7;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      SEL_LO_CAUSE   = 3'd0,
      SEL_HI_CAUSE   = 3'd1,
      SEL_PORT_CAUSE = 3'd2,
      SEL_LO_MASK    = 3'd3,
      SEL_HI_MASK    = 3'd4,
      SEL_PORT_MASK  = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/pic96_lowest.sv
module pic96_lowest #(
   parameter int W     = 32,
   parameter int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   if (W < 2) begin : g_bad_w
      $error("pic96_lowest: W must be at least 2");
   end

   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/pic96_port_cause.sv
module pic96_port_cause #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] line_in,
   input  logic         clr_we,
   input  logic [N-1:0] keep_bits,
   output logic [N-1:0] cause
);
   logic [N-1:0] line_q;
   logic [N-1:0] rise;

   assign rise = line_in & ~line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
         cause  <= '0;
      end else begin
         line_q <= line_in;
         if (clr_we) cause <= (cause & keep_bits) | rise;
         else        cause <= cause | rise;
      end
   end
endmodule

// File: rtl/pic96_resolver.sv
module pic96_resolver #(
   parameter int          DW        = 32,
   parameter int          NW        = 7,
   parameter logic [31:0] LO_FILTER = 32'h3DFF_FFFE,
   parameter logic [31:0] HI_FILTER = 32'h0F00_0DB7,
   parameter int          SUM_LSB   = 24,
   parameter int          PORT_BASE = 64,
   parameter int          HI_BASE   = 32
) (
   input  logic [DW-1:0] lo_cause,
   input  logic [DW-1:0] hi_cause,
   input  logic [DW-1:0] port_cause,
   input  logic [DW-1:0] lo_mask,
   input  logic [DW-1:0] hi_mask,
   input  logic [DW-1:0] port_mask,
   output logic          valid,
   output logic [NW-1:0] num,
   output logic          spurious,
   output logic          cpu_irq
);
   localparam int IW = $clog2(DW);

   logic [DW-1:0] lo_elig, hi_elig, port_elig;
   logic          lo_any, hi_any, port_any;
   logic [IW-1:0] lo_idx, hi_idx, port_idx;

   assign lo_elig   = lo_cause & LO_FILTER[DW-1:0] & lo_mask;
   assign hi_elig   = hi_cause & HI_FILTER[DW-1:0] & hi_mask;
   assign port_elig = port_cause & port_mask;

   pic96_lowest #(.W(DW), .IDX_W(IW)) u_lo_enc
      (.vec(lo_elig), .any(lo_any), .idx(lo_idx));
   pic96_lowest #(.W(DW), .IDX_W(IW)) u_hi_enc
      (.vec(hi_elig), .any(hi_any), .idx(hi_idx));
   pic96_lowest #(.W(DW), .IDX_W(IW)) u_port_enc
      (.vec(port_elig), .any(port_any), .idx(port_idx));

   always_comb begin
      valid    = 1'b0;
      num      = '0;
      spurious = 1'b1;
      if (lo_any) begin
         valid    = 1'b1;
         spurious = 1'b0;
         num      = NW'(lo_idx);
      end else if (hi_any) begin
         if (int'(hi_idx) >= SUM_LSB) begin
            if (port_any) begin
               valid    = 1'b1;
               spurious = 1'b0;
               num      = NW'(PORT_BASE) + NW'(port_idx);
            end
         end else begin
            valid    = 1'b1;
            spurious = 1'b0;
            num      = NW'(HI_BASE) + NW'(hi_idx);
         end
      end
   end

   assign cpu_irq = lo_any | hi_any;
endmodule

// File: rtl/pic96_top.sv
module pic96_top
   import pic96_pkg::*;
#(
   parameter logic [31:0] LO_FILTER   = 32'h3DFF_FFFE,
   parameter logic [31:0] HI_FILTER   = 32'h0F00_0DB7,
   parameter int          N_PORT      = 32,
   parameter int          SUM_LSB     = 24,
   parameter int          SUM_GROUPS  = 4,
   parameter logic [31:0] HI_MASK_RST = 32'h0F00_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] unit_irq_lo,
   input  logic [DATA_W-1:0] unit_irq_hi,
   input  logic [N_PORT-1:0] gpp_irq,
   output logic              cpu_irq,
   output logic              irq_valid,
   output logic [NUM_W-1:0]  irq_num,
   output logic              irq_spurious
);
   localparam int                GRP_W     = N_PORT / SUM_GROUPS;
   localparam logic [DATA_W-1:0] SUM_FIELD =
      DATA_W'(((64'd1 << SUM_GROUPS) - 64'd1) << SUM_LSB);

   if (N_PORT != DATA_W) begin : g_bad_port
      $error("pic96_top: N_PORT must equal the register width");
   end
   if (N_PORT % SUM_GROUPS != 0) begin : g_bad_grp
      $error("pic96_top: N_PORT must divide evenly into SUM_GROUPS");
   end
   if (SUM_LSB + SUM_GROUPS > DATA_W) begin : g_bad_sum
      $error("pic96_top: summary field exceeds register");
   end

   logic [DATA_W-1:0]     lo_cause_q, hi_raw_q, hi_cause;
   logic [DATA_W-1:0]     lo_mask_q, hi_mask_q, port_mask_q;
   logic [N_PORT-1:0]     port_cause_q;
   logic [SUM_GROUPS-1:0] summary;
   logic                  wr_port_cause;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cause_q <= '0;
         hi_raw_q   <= '0;
      end else begin
         lo_cause_q <= unit_irq_lo;
         hi_raw_q   <= unit_irq_hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_mask_q   <= '0;
         hi_mask_q   <= HI_MASK_RST;
         port_mask_q <= '0;
      end else if (bus_we) begin
         case (reg_sel_e'(bus_addr))
            SEL_LO_MASK:   lo_mask_q   <= bus_wdata;
            SEL_HI_MASK:   hi_mask_q   <= bus_wdata;
            SEL_PORT_MASK: port_mask_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   assign wr_port_cause = bus_we && (reg_sel_e'(bus_addr) == SEL_PORT_CAUSE);

   pic96_port_cause #(.N(N_PORT)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (gpp_irq),
      .clr_we    (wr_port_cause),
      .keep_bits (bus_wdata[N_PORT-1:0]),
      .cause     (port_cause_q)
   );

   for (genvar g = 0; g < SUM_GROUPS; g++) begin : g_sum
      assign summary[g] = |port_cause_q[g*GRP_W +: GRP_W];
   end

   assign hi_cause = (hi_raw_q & ~SUM_FIELD)
                   | (DATA_W'(summary) << SUM_LSB);

   pic96_resolver #(
      .DW        (DATA_W),
      .NW        (NUM_W),
      .LO_FILTER (LO_FILTER),
      .HI_FILTER (HI_FILTER),
      .SUM_LSB   (SUM_LSB),
      .PORT_BASE (2 * DATA_W),
      .HI_BASE   (DATA_W)
   ) u_res (
      .lo_cause   (lo_cause_q),
      .hi_cause   (hi_cause),
      .port_cause (port_cause_q),
      .lo_mask    (lo_mask_q),
      .hi_mask    (hi_mask_q),
      .port_mask  (port_mask_q),
      .valid      (irq_valid),
      .num        (irq_num),
      .spurious   (irq_spurious),
      .cpu_irq    (cpu_irq)
   );

   always_comb begin
      case (reg_sel_e'(bus_addr))
         SEL_LO_CAUSE:   bus_rdata = lo_cause_q;
         SEL_HI_CAUSE:   bus_rdata = hi_cause;
         SEL_PORT_CAUSE: bus_rdata = port_cause_q;
         SEL_LO_MASK:    bus_rdata = lo_mask_q;
         SEL_HI_MASK:    bus_rdata = hi_mask_q;
         SEL_PORT_MASK:  bus_rdata = port_mask_q;
         default:        bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pic96_chk.sv
module pic96_chk #(
   parameter logic [31:0] LO_FILTER = 32'h3DFF_FFFE
) (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  bus_addr,
   input logic        bus_we,
   input logic [31:0] lo_cause,
   input logic [31:0] lo_mask,
   input logic [31:0] port_cause,
   input logic        irq_valid,
   input logic [6:0]  irq_num,
   input logic        cpu_irq
);
   AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_num <= 7'd95)); // R1

   AST_LO_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_num < 7'd32) |-> LO_FILTER[irq_num[4:0]]); // R2

   AST_LO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (|(lo_cause & lo_mask & LO_FILTER)) |-> (irq_valid && irq_num < 7'd32)); // R3

   AST_PORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == 3'd2) |=> ((port_cause & $past(port_cause)) == $past(port_cause))); // R7

   AST_CPU_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> cpu_irq); // R10
endmodule

bind pic96_top pic96_chk #(.LO_FILTER(LO_FILTER)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_we     (bus_we),
   .lo_cause   (lo_cause_q),
   .lo_mask    (lo_mask_q),
   .port_cause (port_cause_q),
   .irq_valid  (irq_valid),
   .irq_num    (irq_num),
   .cpu_irq    (cpu_irq)
);

// File: tb/pic96_top_tb.sv
module pic96_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] unit_irq_lo = '0;
   logic [31:0] unit_irq_hi = '0;
   logic [31:0] gpp_irq = '0;
   logic        cpu_irq, irq_valid, irq_spurious;
   logic [6:0]  irq_num;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pic96_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .unit_irq_lo(unit_irq_lo), .unit_irq_hi(unit_irq_hi), .gpp_irq(gpp_irq),
      .cpu_irq(cpu_irq), .irq_valid(irq_valid), .irq_num(irq_num),
      .irq_spurious(irq_spurious)
   );

   // lo[136:105] hi[104:73] lo_mask[72:41] hi_mask[40:9] valid[8] num[7:1] cpu[0]
   localparam int NV = 11;
   localparam logic [136:0] VEC [NV] = '{
      {32'h0000_0010, 32'h0, 32'hFFFF_FFFF, 32'h0,         1'b1, 7'd4,  1'b1}, // R1
      {32'h0000_0001, 32'h0, 32'hFFFF_FFFF, 32'h0,         1'b0, 7'd0,  1'b0}, // R2
      {32'hC200_0000, 32'h0, 32'hFFFF_FFFF, 32'h0,         1'b0, 7'd0,  1'b0}, // R2
      {32'h0000_0100, 32'h2, 32'h0,         32'hFFFF_FFFF, 1'b1, 7'd33, 1'b1}, // R9
      {32'h8000_0006, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 7'd1,  1'b1}, // R3
      {32'h0, 32'h0000_0008, 32'h0,         32'hFFFF_FFFF, 1'b0, 7'd0,  1'b0}, // R2
      {32'h0, 32'h0000_1400, 32'h0,         32'hFFFF_FFFF, 1'b1, 7'd42, 1'b1}, // R4
      {32'h0, 32'h0F00_0000, 32'h0,         32'hFFFF_FFFF, 1'b0, 7'd0,  1'b0}, // R5
      {32'h0, 32'h0000_0880, 32'h0,         32'h0000_0800, 1'b1, 7'd43, 1'b1}, // R9
      {32'h3000_0000, 32'h0, 32'hFFFF_FFFF, 32'h0,         1'b1, 7'd28, 1'b1}, // R1
      {32'h1000_0000, 32'h1, 32'hEFFF_FFFF, 32'h0000_0001, 1'b1, 7'd32, 1'b1}  // R3
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, "read", bus_rdata, exp);
   endtask

   task automatic out_chk(input string req, input bit v, input logic [6:0] n, input bit c);
      #1;
      chk(req, "valid", 32'(irq_valid), 32'(v));
      chk(req, "spurious", 32'(irq_spurious), 32'(!v));
      chk(req, "num", 32'(irq_num), v ? 32'(n) : 32'd0);
      chk(req, "cpu_irq", 32'(cpu_irq), 32'(c));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state, R9 and R6
      rd_chk("R9", 3'd3, 32'h0);
      rd_chk("R9", 3'd4, 32'h0F00_0000);
      rd_chk("R9", 3'd5, 32'h0);
      out_chk("R6", 1'b0, 7'd0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         wr(3'd3, VEC[i][72:41]);
         wr(3'd4, VEC[i][40:9]);
         unit_irq_lo = VEC[i][136:105];
         unit_irq_hi = VEC[i][104:73];
         @(negedge clk);
         out_chk("R1-table", VEC[i][8], VEC[i][7:1], VEC[i][0]);
      end

      unit_irq_lo = '0; unit_irq_hi = '0;
      wr(3'd3, 32'h0);
      wr(3'd4, 32'h0F00_0000);
      wr(3'd5, 32'hFFFF_FFFF);
      rd_chk("R9", 3'd5, 32'hFFFF_FFFF);

      // R7: edge capture and hold
      @(negedge clk); gpp_irq = 32'h20;
      @(negedge clk); gpp_irq = 32'h0;
      rd_chk("R7", 3'd2, 32'h20);
      out_chk("R5", 1'b1, 7'd69, 1'b1);
      @(negedge clk);
      rd_chk("R7", 3'd2, 32'h20);

      // R5: second group, summary composition
      gpp_irq = 32'h0010_0000;
      @(negedge clk); gpp_irq = 32'h0;
      rd_chk("R7", 3'd2, 32'h0010_0020);
      rd_chk("R5", 3'd1, 32'h0500_0000);
      out_chk("R5", 1'b1, 7'd69, 1'b1);

      // R8: acknowledge one source
      wr(3'd2, ~32'h20);
      rd_chk("R8", 3'd2, 32'h0010_0000);
      out_chk("R8", 1'b1, 7'd84, 1'b1);

      // R6 / R10: summary wins but port bit masked
      wr(3'd5, 32'hFFEF_FFFF);
      out_chk("R6", 1'b0, 7'd0, 1'b1);
      wr(3'd4, 32'h0);
      out_chk("R10", 1'b0, 7'd0, 1'b0);
      wr(3'd4, 32'h0F00_0000);
      wr(3'd5, 32'hFFFF_FFFF);

      // R8: clear-all write colliding with a new edge
      @(negedge clk);
      bus_addr = 3'd2; bus_wdata = 32'h0; bus_we = 1'b1; gpp_irq = 32'h8;
      @(negedge clk);
      bus_we = 1'b0; gpp_irq = 32'h0;
      rd_chk("R8", 3'd2, 32'h0000_0008);
      out_chk("R8", 1'b1, 7'd67, 1'b1);

      // R11: cause registers ignore writes
      unit_irq_lo = 32'h40;
      wr(3'd0, 32'hFFFF_FFFF);
      wr(3'd1, 32'hFFFF_FFFF);
      rd_chk("R11", 3'd0, 32'h40);
      rd_chk("R11", 3'd1, 32'h0100_0000);
      wr(3'd3, 32'hFFFF_FFFF);
      out_chk("R3", 1'b1, 7'd6, 1'b1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule